// File: doc/BRIEF.md
# Cascadable Segment Line Latch

This block is the digital front end of one column-driver chip in a dot-matrix LCD panel, where several such chips are chained along one scan line. A display controller presents pixel data four bits at a time together with a shift strobe (one system-clock pulse per falling edge of the controller's shift clock). While the chip's enable input is high, each strobe writes one nibble into a first-stage line latch at the position held by an address counter. The fill runs either from the lowest-numbered output upward or from the highest downward, as chosen by a direction input. Once the chip has its full share of the line, it raises its cascade output so that the next chip in the chain starts capturing.

A line strobe copies the whole first-stage latch into a second-stage latch in one step. It also returns the address counter to the start and drops the cascade output. Each output then gets a registered two-bit drive-level code. The code is worked out from the held pixel, the frame-alternation input and the display-off input. The analog level shifters and bias generation that act on these codes are outside the block.

Top module: `seg_latch_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `chain_out` is 0 and every level code is 2'b00.
- R2: A shift strobe writes nothing while `chain_in` is low. The second-stage contents loaded afterwards show no trace of such strobes.
- R3: With `dir_rev` low, nibble k of a line (k = 0 for the first strobe after a line strobe) sets output 4k+b from `nib_in[b]`, so bit 0 lands on the lowest output of its group.
- R4: With `dir_rev` high, nibble k bit b sets output 79-(4k+b). This is the forward placement mirrored across the line.
- R5: After 20 nibbles have been captured, later shift strobes leave the first-stage latch unchanged until the next line strobe.
- R6: `chain_out` goes to 1 on the first shift strobe after the 20th capture. It stays 1 until a line strobe, and goes to 0 at that strobe's clock edge.
- R7: A line strobe copies the first-stage latch to the second stage. Captures between line strobes do not change the level codes.
- R8: Level code per output (bits 2p+1:2p for output p): with `alt_in` low, an ON pixel gives 2'b11 and an OFF pixel gives 2'b10. With `alt_in` high, ON gives 2'b00 and OFF gives 2'b01.
- R9: While `disp_off` is high, every level code is 2'b00 whatever the pixel and `alt_in`.
- R10: A line strobe returns the address counter to the start position, so the next capture writes nibble position 0 even after a partial line.
- R11: Level codes change only at the clock edge that samples a line strobe, or a changed `alt_in` or `disp_off`. They never change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_stb | input | 1 | One-cycle pulse per shift-clock falling edge |
| nib_in | input | 4 | Pixel nibble, 1 = ON (dark) |
| dir_rev | input | 1 | 0 fills upward from output 0, 1 fills downward from output 79 |
| chain_in | input | 1 | Capture enable from the previous chip |
| load_stb | input | 1 | Line strobe: copy line to second stage, restart address |
| alt_in | input | 1 | Frame-alternation select |
| disp_off | input | 1 | Force all outputs to the non-display level |
| chain_out | output | 1 | Capture enable for the next chip |
| lvl_out | output | 160 | Two-bit drive-level code per output |

## Verification
The bench fills complete lines in both directions with several nibble patterns and under both alternation phases. A wrong bit order inside a nibble, or a wrong mirroring in reverse mode, therefore shows up as misplaced ON cells. It checks the cascade output around the 20th capture and the one after it, which catches a handoff that comes one strobe early or late. It also checks that a 21st nibble does not overwrite the last group. It sends strobes with the enable low, splits a line with a mid-line line strobe, and samples the level codes just before and just after an alternation change. This exposes a design that ignores the enable, that resumes at the old address, or that updates its outputs combinationally or while nibbles are being captured.

// File: rtl/seg_latch_pkg.sv
package seg_latch_pkg;

    typedef enum logic [1:0] {
        LVL_LOW_FULL  = 2'b00,
        LVL_LOW_MID   = 2'b01,
        LVL_HIGH_MID  = 2'b10,
        LVL_HIGH_FULL = 2'b11
    } drive_lvl_e;

    typedef struct packed {
        logic capture;
        logic restart;
        logic handoff;
    } addr_evt_t;

    // Drive-level selection for one output.
    function automatic drive_lvl_e pick_level(input logic pix_on,
                                              input logic alt,
                                              input logic off);
        drive_lvl_e r;
        if (off)
            r = LVL_LOW_FULL;
        else if (!alt)
            r = pix_on ? LVL_HIGH_FULL : LVL_HIGH_MID;
        else
            r = pix_on ? LVL_LOW_FULL : LVL_LOW_MID;
        return r;
    endfunction

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
    import seg_latch_pkg::*;
#(
    parameter int NIB_COUNT = 20,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_stb,
    input  logic              load_stb,
    input  logic              chain_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              chain_out
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NIB_COUNT - 1);

    logic [ADDR_W-1:0] addr_q;
    logic              full_q;
    logic              chain_q;
    addr_evt_t         evt;

    always_comb begin
        evt.restart = load_stb;
        evt.capture = !load_stb && shift_stb && chain_in && !full_q;
        evt.handoff = !load_stb && shift_stb && full_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            full_q  <= 1'b0;
            chain_q <= 1'b0;
        end else if (evt.restart) begin
            addr_q  <= '0;
            full_q  <= 1'b0;
            chain_q <= 1'b0;
        end else begin
            if (evt.capture) begin
                if (addr_q == LAST_ADDR)
                    full_q <= 1'b1;
                else
                    addr_q <= addr_q + 1'b1;
            end
            if (evt.handoff)
                chain_q <= 1'b1;
        end
    end

    assign wr_en     = evt.capture;
    assign wr_addr   = addr_q;
    assign chain_out = chain_q;

endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
    parameter int SEG_COUNT = 80,
    parameter int BUS_W     = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 dir_rev,
    input  logic [BUS_W-1:0]     nib_in,
    input  logic                 load_stb,
    output logic [SEG_COUNT-1:0] hold_next
);

    logic [SEG_COUNT-1:0] fill_q;
    logic [SEG_COUNT-1:0] fill_next;
    logic [SEG_COUNT-1:0] hold_q;

    for (genvar p = 0; p < SEG_COUNT; p++) begin : g_bit
        localparam int FWD_GRP = p / BUS_W;
        localparam int FWD_BIT = p % BUS_W;
        localparam int MIR_POS = SEG_COUNT - 1 - p;
        localparam int REV_GRP = MIR_POS / BUS_W;
        localparam int REV_BIT = MIR_POS % BUS_W;

        logic hit_fwd;
        logic hit_rev;

        assign hit_fwd = wr_en && !dir_rev && (wr_addr == ADDR_W'(FWD_GRP));
        assign hit_rev = wr_en &&  dir_rev && (wr_addr == ADDR_W'(REV_GRP));

        always_comb begin
            if (hit_fwd)
                fill_next[p] = nib_in[FWD_BIT];
            else if (hit_rev)
                fill_next[p] = nib_in[REV_BIT];
            else
                fill_next[p] = fill_q[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            hold_q <= '0;
        end else begin
            fill_q <= fill_next;
            hold_q <= hold_next;
        end
    end

    assign hold_next = load_stb ? fill_q : hold_q;

endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
    import seg_latch_pkg::*;
#(
    parameter int SEG_COUNT = 80
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SEG_COUNT-1:0]   hold_next,
    input  logic                   alt_in,
    input  logic                   disp_off,
    output logic [2*SEG_COUNT-1:0] lvl_out
);

    logic [2*SEG_COUNT-1:0] lvl_next;
    logic [2*SEG_COUNT-1:0] lvl_q;

    for (genvar p = 0; p < SEG_COUNT; p++) begin : g_out
        drive_lvl_e sel;
        assign sel = pick_level(hold_next[p], alt_in, disp_off);
        assign lvl_next[2*p +: 2] = sel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= '0;
        else
            lvl_q <= lvl_next;
    end

    assign lvl_out = lvl_q;

endmodule

// File: rtl/seg_latch_top.sv
module seg_latch_top
    import seg_latch_pkg::*;
#(
    parameter int SEG_COUNT = 80,
    parameter int BUS_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift_stb,
    input  logic [BUS_W-1:0]       nib_in,
    input  logic                   dir_rev,
    input  logic                   chain_in,
    input  logic                   load_stb,
    input  logic                   alt_in,
    input  logic                   disp_off,
    output logic                   chain_out,
    output logic [2*SEG_COUNT-1:0] lvl_out
);

    localparam int NIB_COUNT = SEG_COUNT / BUS_W;
    localparam int ADDR_W    = (NIB_COUNT > 1) ? $clog2(NIB_COUNT) : 1;

    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [SEG_COUNT-1:0] hold_next;

    seg_addr_ctrl #(
        .NIB_COUNT(NIB_COUNT),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .shift_stb(shift_stb),
        .load_stb (load_stb),
        .chain_in (chain_in),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .chain_out(chain_out)
    );

    seg_line_latch #(
        .SEG_COUNT(SEG_COUNT),
        .BUS_W    (BUS_W),
        .ADDR_W   (ADDR_W)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .dir_rev  (dir_rev),
        .nib_in   (nib_in),
        .load_stb (load_stb),
        .hold_next(hold_next)
    );

    seg_level_map #(
        .SEG_COUNT(SEG_COUNT)
    ) u_map (
        .clk      (clk),
        .rst      (rst),
        .hold_next(hold_next),
        .alt_in   (alt_in),
        .disp_off (disp_off),
        .lvl_out  (lvl_out)
    );

endmodule

// File: rtl/seg_latch_chk.sv
module seg_latch_chk #(
    parameter int SEG_COUNT = 80,
    parameter int ADDR_W    = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   shift_stb,
    input logic                   load_stb,
    input logic                   alt_in,
    input logic                   disp_off,
    input logic                   chain_out,
    input logic [2*SEG_COUNT-1:0] lvl_out,
    input logic [ADDR_W-1:0]      addr
);

    localparam int NIB_COUNT = SEG_COUNT / 4;

    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    // R6: cascade output rises only after a shift strobe without a line strobe
    assert_chain_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(chain_out) |-> $past(shift_stb && !load_stb));

    // R6: line strobe drops the cascade output
    assert_chain_clear_R6: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !chain_out);

    // R6: cascade output holds until a line strobe
    assert_chain_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (chain_out && !load_stb) |=> chain_out);

    // R9: display-off forces the non-display code everywhere
    assert_blank_R9: assert property (@(posedge clk) disable iff (rst)
        disp_off |=> (lvl_out == '0));

    // R11: no level change without a line strobe or a control change
    assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !load_stb && $stable(alt_in) && $stable(disp_off))
        |=> $stable(lvl_out));

    // R10: line strobe returns the counter to the start
    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (addr == '0));

    // R5: the counter stays inside the line
    assert_addr_range_R5: assert property (@(posedge clk) disable iff (rst)
        addr <= ADDR_W'(NIB_COUNT - 1));

endmodule

bind seg_latch_top seg_latch_chk #(
    .SEG_COUNT(SEG_COUNT),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .shift_stb(shift_stb),
    .load_stb (load_stb),
    .alt_in   (alt_in),
    .disp_off (disp_off),
    .chain_out(chain_out),
    .lvl_out  (lvl_out),
    .addr     (wr_addr)
);

// File: tb/seg_latch_top_tb_top.sv
`timescale 1ns/1ps
module seg_latch_top_tb_top;

    localparam int SEG = 80;
    localparam int NIB = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           shift_stb = 1'b0;
    logic [3:0]     nib_in = '0;
    logic           dir_rev = 1'b0;
    logic           chain_in = 1'b1;
    logic           load_stb = 1'b0;
    logic           alt_in = 1'b0;
    logic           disp_off = 1'b0;
    logic           chain_out;
    logic [2*SEG-1:0] lvl_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [SEG-1:0] m1 = '0;
    logic [SEG-1:0] m2 = '0;
    int             m_cnt = 0;
    logic           m_full = 1'b0;
    logic           m_chain = 1'b0;

    always #5 clk = ~clk;

    seg_latch_top #(.SEG_COUNT(SEG), .BUS_W(4)) dut_i (
        .clk(clk), .rst(rst), .shift_stb(shift_stb), .nib_in(nib_in),
        .dir_rev(dir_rev), .chain_in(chain_in), .load_stb(load_stb),
        .alt_in(alt_in), .disp_off(disp_off), .chain_out(chain_out),
        .lvl_out(lvl_out)
    );

    function automatic logic [2*SEG-1:0] exp_lvl(input logic [SEG-1:0] l2,
                                                 input logic a, input logic o);
        logic [2*SEG-1:0] r;
        for (int p = 0; p < SEG; p++) begin
            if (o)        r[2*p +: 2] = 2'b00;
            else if (!a)  r[2*p +: 2] = l2[p] ? 2'b11 : 2'b10;
            else          r[2*p +: 2] = l2[p] ? 2'b00 : 2'b01;
        end
        return r;
    endfunction

    task automatic chk_lvl(input string tag);
        logic [2*SEG-1:0] e;
        e = exp_lvl(m2, alt_in, disp_off);
        n_chk++;
        if (lvl_out !== e) begin
            n_bad++;
            $display("FAIL %s lvl act=%h exp=%h", tag, lvl_out, e);
        end
    endtask

    task automatic chk_chain(input string tag, input logic e);
        n_chk++;
        if (chain_out !== e) begin
            n_bad++;
            $display("FAIL %s chain_out act=%b exp=%b", tag, chain_out, e);
        end
    endtask

    // One clock: inputs applied at a falling edge, model updated after the next.
    task automatic step(input logic s, input logic [3:0] n, input logic l);
        shift_stb = s; nib_in = n; load_stb = l;
        @(negedge clk);
        shift_stb = 1'b0; load_stb = 1'b0;
        if (l) begin
            m2 = m1; m_cnt = 0; m_full = 1'b0; m_chain = 1'b0;
        end else if (s) begin
            if (m_full) m_chain = 1'b1;
            else if (chain_in) begin
                for (int b = 0; b < 4; b++) begin
                    int pos;
                    pos = 4*m_cnt + b;
                    if (dir_rev) pos = SEG - 1 - pos;
                    m1[pos] = n[b];
                end
                if (m_cnt == NIB-1) m_full = 1'b1;
                else m_cnt++;
            end
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk_chain("R1 reset", 1'b0);
        n_chk++;
        if (lvl_out !== '0) begin
            n_bad++; $display("FAIL R1 reset lvl act=%h exp=0", lvl_out);
        end
        rst = 1'b0;
        chk_chain("R1 first cycle", 1'b0);
        n_chk++;
        if (lvl_out !== '0) begin
            n_bad++; $display("FAIL R1 first cycle lvl act=%h exp=0", lvl_out);
        end
        step(1'b0, 4'h0, 1'b0);
        chk_lvl("R8 idle after reset");

        // Full lines in both directions, several patterns, both phases
        for (int seed = 0; seed < 6; seed++) begin
            dir_rev = seed[0];
            alt_in  = seed[1];
            step(1'b0, 4'h0, 1'b0);
            for (int k = 0; k < NIB; k++) begin
                step(1'b1, 4'((k*7 + seed*5 + 3) & 15), 1'b0);
                if (k == NIB-2) chk_chain("R6 before 20th", 1'b0);
            end
            chk_chain("R6 at 20th", 1'b0);
            chk_lvl("R7 no change during capture");
            step(1'b1, ~4'((seed*3) & 15), 1'b0);
            chk_chain("R6 after extra strobe", 1'b1);
            step(1'b1, 4'h5, 1'b0);
            chk_chain("R6 held", 1'b1);
            step(1'b0, 4'h0, 1'b1);
            chk_chain("R6 cleared by load", 1'b0);
            chk_lvl(dir_rev ? "R4 R5 reverse line" : "R3 R5 forward line");
        end

        // Every nibble value at every position, forward then reverse
        for (int v = 0; v < 16; v++) begin
            dir_rev = v[0];
            for (int k = 0; k < NIB; k++) step(1'b1, 4'((v + k) & 15), 1'b0);
            step(1'b0, 4'h0, 1'b1);
            chk_lvl(dir_rev ? "R4 sweep" : "R3 sweep");
        end

        // Single nibble in reverse lands at the top of the line
        dir_rev = 1'b0;
        for (int k = 0; k < NIB; k++) step(1'b1, 4'h0, 1'b0);
        step(1'b0, 4'h0, 1'b1);
        dir_rev = 1'b1;
        step(1'b1, 4'h1, 1'b0);
        step(1'b0, 4'h0, 1'b1);
        n_chk++;
        if (lvl_out[2*79 +: 2] !== (alt_in ? 2'b00 : 2'b11) ||
            lvl_out[2*76 +: 2] !== (alt_in ? 2'b01 : 2'b10)) begin
            n_bad++;
            $display("FAIL R4 top output act=%b/%b", lvl_out[2*79 +: 2], lvl_out[2*76 +: 2]);
        end
        chk_lvl("R4 single nibble");

        // Enable low: strobes are ignored
        dir_rev = 1'b0;
        chain_in = 1'b0;
        for (int k = 0; k < 8; k++) step(1'b1, 4'hF, 1'b0);
        chk_chain("R2 no handoff", 1'b0);
        chain_in = 1'b1;
        step(1'b0, 4'h0, 1'b1);
        chk_lvl("R2 strobes ignored");

        // Partial line, line strobe, restart at position 0
        for (int k = 0; k < 3; k++) step(1'b1, 4'hF, 1'b0);
        step(1'b0, 4'h0, 1'b1);
        chk_lvl("R10 partial line");
        step(1'b1, 4'h0, 1'b0);
        step(1'b0, 4'h0, 1'b1);
        chk_lvl("R10 restart at start");

        // Alternation timing and display-off
        alt_in = ~alt_in;
        #1;
        n_chk++;
        if (lvl_out !== exp_lvl(m2, ~alt_in, disp_off)) begin
            n_bad++; $display("FAIL R11 early change act=%h", lvl_out);
        end
        step(1'b0, 4'h0, 1'b0);
        chk_lvl("R8 R11 after alt edge");
        disp_off = 1'b1;
        step(1'b0, 4'h0, 1'b0);
        chk_lvl("R9 blank");
        alt_in = ~alt_in;
        for (int k = 0; k < NIB; k++) step(1'b1, 4'hA, 1'b0);
        step(1'b0, 4'h0, 1'b1);
        chk_lvl("R9 blank after load");
        disp_off = 1'b0;
        step(1'b0, 4'h0, 1'b0);
        chk_lvl("R9 released");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule